// File: doc/BRIEF.md
# Chained DAC Serial Frame Master

This block sits on the host side of a serial link to a chain of identical DAC devices wired output-to-input. Each device has a 24-bit input shift register, and whatever is clocked in beyond 24 bits spills out of that register into the next device. One transaction therefore delivers a 24-bit word to every device in the chain. The master lowers the frame select line, sends a gated burst of exactly 24 × N serial clocks while shifting out data, and raises frame select after the last falling clock edge. Raising frame select latches the data in every device at once.

The host presents all N words at the same time as one flat vector and hands them over with a valid/ready handshake. `start_ready` is high only while the block is idle. A request that arrives while `start_ready` is low is not taken and is not remembered, so the host must hold `start_valid` until it sees the two high together. After the burst, frame select stays high for a parameterised minimum gap. A one-cycle `done` pulse then marks the end of the transaction.

The serial clock idles high and falls once for each data bit. Devices sample on the falling edge, so the block changes the data line only while the clock is high. The half-period of the serial clock and the length of the gap are counted in system clocks.

Top module: `dcs_frame_master`

## Requirements
- R1: After reset, `sync_n`=1, `sclk`=1, `busy`=0, `done`=0 and `start_ready`=1.
- R2: Each transaction has exactly N_DEV×WORD_W falling edges of `sclk` (72 with the defaults). `sclk` stays high whenever `sync_n` is high.
- R3: `sync_n` falls only after a request is accepted, and only before the first falling edge of `sclk`. It then stays low through the whole burst. It rises at least HALF_CYC cycles after the last falling edge, with `sclk` high.
- R4: The word for device k (device 0 is nearest the host) sits at `words_i[WORD_W*k +: WORD_W]`. The block sends the bits of `words_i` from bit N_DEV×WORD_W−1 down to bit 0, one bit per falling edge. The farthest device's word therefore goes first, each word MSB first.
- R5: `sdin` changes only while `sclk` is high. It is stable through every cycle in which `sclk` is low.
- R6: Between two transactions, `sync_n` stays high for at least GAP_CYC system clocks.
- R7: `start_ready` is low while a transaction is in progress. A `start_valid` seen while `start_ready` is low has no effect: it changes neither the data nor the number of clocks, and it starts no later frame.
- R8: `done` is high for exactly one cycle per transaction, in the first cycle after the gap. `busy` is already low in that cycle.
- R9: `busy` goes high, and `sync_n` goes low, in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request to send `words_i` |
| start_ready | output | 1 | High when a request can be accepted (idle) |
| words_i | input | N_DEV×WORD_W | Words for all devices; device k at bits WORD_W*k upward |
| busy | output | 1 | Transaction in progress, including the gap |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| sync_n | output | 1 | Active-low frame select to the chain |
| sclk | output | 1 | Gated serial clock, idles high |
| sdin | output | 1 | Serial data into the first device |

## Verification
A wrong phase timer or state shows at the ports within one serial half-period. It appears as a clock edge while frame select is high, a missing gap, or a data change while the clock is low. A wrong bit counter shows when frame select rises: the number of falling edges is off, and the words latched by the devices are shifted against their expected positions. A wrong shift order or load position corrupts the captured 72-bit stream, which the bench compares in full after every frame. A handshake that lets a request in while busy shows as extra clocks or an extra frame within a few cycles of `done`.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL,
    ST_GAP
  } dcs_state_e;
endpackage

// File: rtl/dcs_phase_timer.sv
// Counts the system cycles spent in one phase; restarts on every phase change.
module dcs_phase_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] len,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  assign expired = (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (restart)    cnt <= '0;
    else if (!expired)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dcs_shifter.sv
// Parallel-load, MSB-first shift register feeding the serial data line.
module dcs_shifter #(
  parameter int WIDTH = 72
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             shift,
  output logic             msb
);
  logic [WIDTH-1:0] sreg;

  assign msb = sreg[WIDTH-1];

  always_ff @(posedge clk) begin
    if (!rst_n)      sreg <= '0;
    else if (load)   sreg <= din;
    else if (shift)  sreg <= {sreg[WIDTH-2:0], 1'b0};
  end
endmodule

// File: rtl/dcs_frame_master.sv
module dcs_frame_master
  import dcs_pkg::*;
#(
  parameter int N_DEV    = 3,
  parameter int WORD_W   = 24,
  parameter int HALF_CYC = 2,   // sclk half-period in system clocks, >= 1
  parameter int GAP_CYC  = 2    // minimum sync_n high time in system clocks, >= 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_valid,
  output logic                    start_ready,
  input  logic [N_DEV*WORD_W-1:0] words_i,
  output logic                    busy,
  output logic                    done,
  output logic                    sync_n,
  output logic                    sclk,
  output logic                    sdin
);
  localparam int TOTAL  = N_DEV * WORD_W;
  localparam int BIT_W  = $clog2(TOTAL + 1);
  localparam int PH_MAX = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);

  dcs_state_e        state, state_nxt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [PH_W-1:0]   phase_len;
  logic              ph_exp, accept, shift_en, last_bit;

  assign accept      = start_valid && start_ready;
  assign last_bit    = (bit_cnt == BIT_W'(TOTAL - 1));
  assign phase_len   = (state == ST_GAP) ? PH_W'(GAP_CYC) : PH_W'(HALF_CYC);
  assign shift_en    = (state == ST_LOW) && (state_nxt == ST_HIGH);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE: if (start_valid) state_nxt = ST_LEAD;
      ST_LEAD: if (ph_exp)      state_nxt = ST_LOW;
      ST_LOW:  if (ph_exp)      state_nxt = last_bit ? ST_TAIL : ST_HIGH;
      ST_HIGH: if (ph_exp)      state_nxt = ST_LOW;
      ST_TAIL: if (ph_exp)      state_nxt = ST_GAP;
      ST_GAP:  if (ph_exp)      state_nxt = ST_IDLE;
      default:                  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= state_nxt;
      done  <= (state == ST_GAP) && (state_nxt == ST_IDLE);
      if (accept)
        bit_cnt <= '0;
      else if (state == ST_LOW && ph_exp)
        bit_cnt <= bit_cnt + 1'b1;
    end
  end

  dcs_phase_timer #(.CNT_W(PH_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_nxt != state),
    .len     (phase_len),
    .expired (ph_exp)
  );

  dcs_shifter #(.WIDTH(TOTAL)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .din   (words_i),
    .shift (shift_en),
    .msb   (sdin)
  );

  assign busy        = (state != ST_IDLE);
  assign start_ready = (state == ST_IDLE);
  assign sclk        = (state != ST_LOW);
  assign sync_n      = (state == ST_IDLE) || (state == ST_GAP);

  // ---------------- assertions ----------------
  logic             sclk_q, sync_q;
  logic [BIT_W-1:0] fall_cnt;
  logic [PH_W-1:0]  high_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q   <= 1'b1;
      sync_q   <= 1'b1;
      fall_cnt <= '0;
      high_cnt <= PH_W'(GAP_CYC);
    end else begin
      sclk_q <= sclk;
      sync_q <= sync_n;
      if (sync_q && !sync_n)      fall_cnt <= '0;
      else if (sclk_q && !sclk)   fall_cnt <= fall_cnt + 1'b1;
      if (!sync_n)                      high_cnt <= '0;
      else if (high_cnt < PH_W'(GAP_CYC)) high_cnt <= high_cnt + 1'b1;
    end
  end

  assert_idle_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> sclk);
  assert_burst_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_q && sync_n) |-> (fall_cnt == BIT_W'(TOTAL)));
  assert_sync_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_n) |-> $past(start_valid && start_ready));
  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> $stable(sdin));
  assert_min_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && !sync_n) |-> (high_cnt >= PH_W'(GAP_CYC)));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/dcs_frame_master_tb.sv
module dcs_frame_master_tb;
  localparam int N_DEV = 3, WORD_W = 24, HALF_CYC = 2, GAP_CYC = 2;
  localparam int TOTAL = N_DEV * WORD_W;

  logic clk = 1'b0, rst_n = 1'b0, start_valid = 1'b0;
  logic [TOTAL-1:0] words_i = '0;
  logic start_ready, busy, done, sync_n, sclk, sdin;

  always #5 clk = ~clk;

  dcs_frame_master #(.N_DEV(N_DEV), .WORD_W(WORD_W), .HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .words_i(words_i), .busy(busy), .done(done), .sync_n(sync_n), .sclk(sclk), .sdin(sdin));

  int n_chk = 0, n_bad = 0;
  int cyc = 0, falls = 0, bad_fall = 0, sdin_bad = 0, tail_bad = 0;
  int done_cnt = 0, done_dbl = 0, last_fall = 0, rise_cyc = 0, last_high = 1000;
  logic [TOTAL-1:0] cap = '0;
  logic p_sclk = 1'b1, p_sync = 1'b1, p_sdin = 1'b0, p_done = 1'b0;

  // port monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (p_sclk && !sclk) begin
        falls <= falls + 1;
        cap <= {cap[TOTAL-2:0], sdin};
        last_fall <= cyc;
        if (sync_n) bad_fall <= bad_fall + 1;
      end
      if (!sclk && !p_sclk && sdin != p_sdin) sdin_bad <= sdin_bad + 1;
      if (sync_n && !p_sync) begin
        rise_cyc <= cyc;
        if ((cyc - last_fall) < HALF_CYC || !sclk) tail_bad <= tail_bad + 1;
      end
      if (!sync_n && p_sync) last_high <= cyc - rise_cyc;
      if (done) done_cnt <= done_cnt + 1;
      if (done && p_done) done_dbl <= done_dbl + 1;
    end
    p_sclk <= sclk; p_sync <= sync_n; p_sdin <= sdin; p_done <= done;
  end

  task automatic chk(input bit ok, input string req, input logic [TOTAL-1:0] act, input logic [TOTAL-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(sync_n == 1 && sclk == 1, "R1 sync_n/sclk", {sync_n, sclk}, 2'b11);
    chk(busy == 0 && done == 0 && start_ready == 1, "R1 busy/done/ready", {busy, done, start_ready}, 3'b001);
  endtask

  task automatic t_single(input logic [TOTAL-1:0] w);
    int f0, b0, s0, t0, d0, dd0;
    bit ok;
    f0 = falls; b0 = bad_fall; s0 = sdin_bad; t0 = tail_bad; d0 = done_cnt; dd0 = done_dbl;
    @(negedge clk);
    words_i = w; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    chk(busy == 1 && sync_n == 0, "R9 busy/sync after accept", {busy, sync_n}, 2'b10);
    wait_done(ok);
    chk(ok, "R8 done seen", ok, 1);
    chk(busy == 0, "R8 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 0, "R8 done one cycle", done, 0);
    chk(falls - f0 == TOTAL, "R2 falling edges", falls - f0, TOTAL);
    chk(cap == w, "R4 bit order", cap, w);
    chk(bad_fall == b0 && tail_bad == t0, "R3 sync framing", (bad_fall - b0) + (tail_bad - t0), 0);
    chk(sdin_bad == s0, "R5 sdin stable while sclk low", sdin_bad - s0, 0);
    chk(done_cnt - d0 == 1 && done_dbl == dd0, "R8 done count", done_cnt - d0, 1);
  endtask

  task automatic t_busy_ignore(input logic [TOTAL-1:0] a, input logic [TOTAL-1:0] b);
    int f0;
    bit ok;
    f0 = falls;
    @(negedge clk);
    words_i = a; start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(start_ready == 0 && busy == 1, "R7 ready low while busy", {start_ready, busy}, 2'b01);
    words_i = b; start_valid = 1'b1;
    repeat (3) @(negedge clk);
    start_valid = 1'b0;
    wait_done(ok);
    chk(ok, "R7 frame completes", ok, 1);
    chk(cap == a, "R7 data unchanged by ignored start", cap, a);
    repeat (30) @(negedge clk);
    chk(falls - f0 == TOTAL, "R7 no extra clocks", falls - f0, TOTAL);
    chk(sync_n == 1 && busy == 0, "R7 no extra frame", {sync_n, busy}, 2'b10);
  endtask

  task automatic t_back_to_back(input logic [TOTAL-1:0] a, input logic [TOTAL-1:0] b);
    int f0;
    bit ok;
    f0 = falls;
    @(negedge clk);
    words_i = a; start_valid = 1'b1;
    @(negedge clk);
    words_i = b;
    wait_done(ok);
    chk(ok, "R6 first frame done", ok, 1);
    @(negedge clk);
    start_valid = 1'b0;
    chk(busy == 1, "R9 second frame started", busy, 1);
    wait_done(ok);
    chk(ok, "R6 second frame done", ok, 1);
    chk(last_high >= GAP_CYC, "R6 sync high gap", last_high, GAP_CYC);
    chk(falls - f0 == 2 * TOTAL, "R2 two bursts", falls - f0, 2 * TOTAL);
    chk(cap == b, "R4 second frame data", cap, b);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single({24'hC30FF0, 24'h800001, 24'h5AA55A});
    t_single({24'hFFFFFF, 24'h000000, 24'hFFFFFF});
    t_single({24'h000001, 24'h000002, 24'h800000});
    t_busy_ignore({24'h123456, 24'h789ABC, 24'hDEF012}, {24'hAAAAAA, 24'h555555, 24'h0F0F0F});
    t_back_to_back({24'h111111, 24'h222222, 24'h333333}, {24'hE1E2E3, 24'h0A0B0C, 24'h7F8081});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule